// File: doc/BRIEF.md
# NAND Two-Plane Cache Program Sequencer

This block is the host side of a parallel x8 NAND flash link. It runs one two-plane program request at a time. A request names a row and a starting column for each of two planes, plus a flag that picks how the second plane is closed. The block writes a load command, five address bytes and the data for the first plane, then closes that plane with a dummy confirm. It waits out the short busy gap and loads the second plane the same way. It closes the second plane with either the cache-write command or the final-page command, waits for the array to go ready, and reads one status byte before it reports completion.

Write data comes from a byte stream with a valid/ready handshake. A beat can carry a data byte, or it can be a column-jump beat. A jump beat makes the block issue the jump command and two new column bytes, and the load then continues at that column. Any beat can carry the end-of-plane mark. Strobe setup, pulse and hold widths are whole clock cycles set by parameters. The busy wait has a cycle limit: when the limit runs out, the block sends the reset command and reports a timeout.

Before it touches the bus, the block checks each request. The two rows must sit in different planes. Each page must lie strictly above the last page accepted for its block.

Top module: `nand_2p_cache_prog`

## Requirements
- R1: During and after reset, with no request in progress, nand_ce_n is 1, nand_we_n is 1, nand_re_n is 1, nand_cle is 0, nand_ale is 0, nand_io_oe is 0, req_ready is 1 and done is 0.
- R2: The first plane is written in this order: command 80h, five address bytes (column low, column high, row bits 7:0, row 15:8, row 23:16, with the row zero-extended to 24 bits), the data bytes in stream order, then command 11h. Commands are written with nand_cle=1 and addresses with nand_ale=1.
- R3: A stream beat with in_jump=1 writes no data byte. It writes command 85h and then two address bytes, the low and high bytes of in_col. Loading then resumes, or the plane closes if that beat had in_last=1.
- R4: After each close command, no write strobe is issued while nand_rb_n is low, other than 70h or FFh. Once nand_rb_n returns high after 11h, the second plane is written as command 80h, five address bytes and its stream.
- R5: The second plane is closed with 10h when req_final=1 and with 15h when req_final=0. The block then waits for nand_rb_n to go high.
- R6: After the final busy period the block writes 70h and reads one byte with nand_re_n. done pulses for one cycle, with err_code 4 if status bit 0 is 1 and 0 otherwise.
- R7: A request whose two rows share the plane bit (row bit PAGE_W) is rejected with err_code 1 and a done pulse. nand_ce_n stays high throughout.
- R8: A request is rejected with err_code 2 and no bus activity if either page field (row bits PAGE_W-1:0) is not above the last page accepted for its block (row bits PAGE_W+BLK_W-1:PAGE_W). Accepted requests record both pages. The plane check of R7 takes priority.
- R9: If nand_rb_n stays low for T_BUSY_MAX cycles after the T_WB settle window, the block writes command FFh and finishes with err_code 3.
- R10: Each bus write holds its latch level and byte for T_SU cycles before nand_we_n falls. nand_we_n stays low for exactly T_WP cycles, and the level and byte are held for T_HLD cycles after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_row_a | input | PAGE_W+BLK_W | First-plane row |
| req_col_a | input | COL_W | First-plane start column |
| req_row_b | input | PAGE_W+BLK_W | Second-plane row |
| req_col_b | input | COL_W | Second-plane start column |
| req_final | input | 1 | Close second plane with 10h instead of 15h |
| in_valid | input | 1 | Stream beat offered |
| in_ready | output | 1 | Stream beat taken |
| in_data | input | 8 | Data byte |
| in_jump | input | 1 | Beat is a column jump |
| in_col | input | COL_W | Jump target column |
| in_last | input | 1 | Beat ends the current plane |
| nand_ce_n | output | 1 | Chip enable, low while a request runs |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe |
| nand_re_n | output | 1 | Read strobe |
| nand_io_out | output | 8 | Byte driven to the bus |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_in | input | 8 | Byte read from the bus |
| nand_rb_n | input | 1 | Ready/busy, low while busy |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 ok, 1 plane, 2 order, 3 timeout, 4 program fail |

## Verification
A wrong sequencer state shows up as a mismatch in the write log captured at each rising edge of nand_we_n, usually within one bus cycle: a missing jump, a wrong address byte or a wrong close command. A wrong page-order record stays hidden until a later request to the same block, when err_code comes out different from the bench's own model. A broken busy wait shows up as a write while nand_rb_n is low, or as a timeout where none belongs.

// File: rtl/nand2p_pkg.sv
package nand2p_pkg;

  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_DATA = 2'd2,
    BK_READ = 2'd3
  } bus_kind_t;

  localparam logic [2:0] EC_OK       = 3'd0;
  localparam logic [2:0] EC_PLANE    = 3'd1;
  localparam logic [2:0] EC_ORDER    = 3'd2;
  localparam logic [2:0] EC_TIMEOUT  = 3'd3;
  localparam logic [2:0] EC_PROGFAIL = 3'd4;

  localparam logic [7:0] OP_LOAD   = 8'h80;
  localparam logic [7:0] OP_JUMP   = 8'h85;
  localparam logic [7:0] OP_DUMMY  = 8'h11;
  localparam logic [7:0] OP_CACHE  = 8'h15;
  localparam logic [7:0] OP_FINAL  = 8'h10;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_RESET  = 8'hFF;

  // address byte idx of the five-byte load address: column first, low byte first
  function automatic logic [7:0] addr_byte(input logic [15:0] col,
                                           input logic [23:0] row,
                                           input logic [2:0]  idx);
    case (idx)
      3'd0:    addr_byte = col[7:0];
      3'd1:    addr_byte = col[15:8];
      3'd2:    addr_byte = row[7:0];
      3'd3:    addr_byte = row[15:8];
      default: addr_byte = row[23:16];
    endcase
  endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand2p_pkg::*;
#(
  parameter int T_SU  = 2,
  parameter int T_WP  = 2,
  parameter int T_HLD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  bus_kind_t  kind,
  input  logic [7:0] wbyte,
  input  logic [7:0] io_in,
  output logic       busy,
  output logic       fin,
  output logic [7:0] rbyte,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe
);
  localparam int TOT = T_SU + T_WP + T_HLD;
  localparam int CW  = $clog2(TOT + 1);
  localparam logic [CW-1:0] LAST_C  = CW'(TOT - 1);
  localparam logic [CW-1:0] FALL_C  = CW'(T_SU);
  localparam logic [CW-1:0] RISE_C  = CW'(T_SU + T_WP);
  localparam logic [CW-1:0] SAMP_C  = CW'(T_SU + T_WP - 1);

  logic          act;
  logic [CW-1:0] cnt;
  bus_kind_t     kind_q;
  logic [7:0]    byte_q;
  logic          strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      cnt    <= '0;
      kind_q <= BK_CMD;
      byte_q <= '0;
      rbyte  <= '0;
    end else if (!act) begin
      if (go) begin
        act    <= 1'b1;
        cnt    <= '0;
        kind_q <= kind;
        byte_q <= wbyte;
      end
    end else begin
      if (kind_q == BK_READ && cnt == SAMP_C) rbyte <= io_in;
      if (cnt == LAST_C) act <= 1'b0;
      else               cnt <= cnt + 1'b1;
    end
  end

  assign strobe = act && (cnt >= FALL_C) && (cnt < RISE_C);
  assign busy   = act;
  assign fin    = act && (cnt == LAST_C);
  assign cle    = act && (kind_q == BK_CMD);
  assign ale    = act && (kind_q == BK_ADDR);
  assign we_n   = !(strobe && kind_q != BK_READ);
  assign re_n   = !(strobe && kind_q == BK_READ);
  assign io_oe  = act && (kind_q != BK_READ);
  assign io_out = byte_q;

endmodule

// File: rtl/nand_busy_wait.sv
module nand_busy_wait #(
  parameter int T_WB       = 4,
  parameter int T_BUSY_MAX = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rb_n,
  output logic ready_evt,
  output logic timeout_evt
);
  localparam int MAXV = (T_WB > T_BUSY_MAX) ? T_WB : T_BUSY_MAX;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] WB_END  = CW'(T_WB - 1);
  localparam logic [CW-1:0] TMO_END = CW'(T_BUSY_MAX - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETTLE, PH_WATCH} ph_t;
  ph_t           ph;
  logic [CW-1:0] cnt;

  assign ready_evt   = (ph == PH_WATCH) && rb_n;
  assign timeout_evt = (ph == PH_WATCH) && !rb_n && (cnt == TMO_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_SETTLE;
          cnt <= '0;
        end
        PH_SETTLE: if (cnt == WB_END) begin
          ph  <= PH_WATCH;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (ready_evt || timeout_evt) ph <= PH_IDLE;
                 else cnt <= cnt + 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/nand_page_order.sv
module nand_page_order #(
  parameter int PAGE_W = 6,
  parameter int BLK_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PAGE_W+BLK_W-1:0] row_a,
  input  logic [PAGE_W+BLK_W-1:0] row_b,
  input  logic                    commit,
  output logic                    plane_clash,
  output logic                    order_bad
);
  localparam int NBLK = 1 << BLK_W;

  logic [PAGE_W-1:0] last_pg [NBLK];
  logic [NBLK-1:0]   seen;

  function automatic logic [BLK_W-1:0] blk_of(input logic [PAGE_W+BLK_W-1:0] r);
    return r[PAGE_W +: BLK_W];
  endfunction

  function automatic logic [PAGE_W-1:0] pg_of(input logic [PAGE_W+BLK_W-1:0] r);
    return r[PAGE_W-1:0];
  endfunction

  logic [BLK_W-1:0]  ba, bb;
  logic [PAGE_W-1:0] pa, pb;
  logic              bad_a, bad_b;

  assign ba = blk_of(row_a);
  assign bb = blk_of(row_b);
  assign pa = pg_of(row_a);
  assign pb = pg_of(row_b);
  assign plane_clash = (ba[0] == bb[0]);
  assign bad_a = seen[ba] && (pa <= last_pg[ba]);
  assign bad_b = seen[bb] && (pb <= last_pg[bb]);
  assign order_bad = bad_a || bad_b;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen[g]    <= 1'b0;
        last_pg[g] <= '0;
      end else if (commit) begin
        if (ba == BLK_W'(g)) begin
          seen[g]    <= 1'b1;
          last_pg[g] <= pa;
        end else if (bb == BLK_W'(g)) begin
          seen[g]    <= 1'b1;
          last_pg[g] <= pb;
        end
      end
    end
  end

endmodule

// File: rtl/nand_2p_cache_prog.sv
module nand_2p_cache_prog
  import nand2p_pkg::*;
#(
  parameter int COL_W      = 13,
  parameter int PAGE_W     = 6,
  parameter int BLK_W      = 5,
  parameter int T_SU       = 2,
  parameter int T_WP       = 2,
  parameter int T_HLD      = 2,
  parameter int T_WB       = 4,
  parameter int T_BUSY_MAX = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [PAGE_W+BLK_W-1:0] req_row_a,
  input  logic [COL_W-1:0]        req_col_a,
  input  logic [PAGE_W+BLK_W-1:0] req_row_b,
  input  logic [COL_W-1:0]        req_col_b,
  input  logic                    req_final,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_jump,
  input  logic [COL_W-1:0]        in_col,
  input  logic                    in_last,
  output logic                    nand_ce_n,
  output logic                    nand_cle,
  output logic                    nand_ale,
  output logic                    nand_we_n,
  output logic                    nand_re_n,
  output logic [7:0]              nand_io_out,
  output logic                    nand_io_oe,
  input  logic [7:0]              nand_io_in,
  input  logic                    nand_rb_n,
  output logic                    done,
  output logic [2:0]              err_code
);
  localparam int ROW_W = PAGE_W + BLK_W;

  typedef enum logic [3:0] {
    S_IDLE, S_PCMD, S_ADDR, S_DATA, S_JCMD, S_JADDR, S_CONF,
    S_WAIT, S_STCMD, S_STRD, S_RSTCMD, S_DONE
  } st_t;

  st_t              st;
  logic             pl;
  logic [2:0]       aidx;
  logic             jidx;
  logic             last_q;
  logic             final_q;
  logic [ROW_W-1:0] row_a_q, row_b_q;
  logic [COL_W-1:0] col_a_q, col_b_q, jcol_q;
  logic [2:0]       err_q;

  // named internal events
  logic evt_accept, evt_reject, evt_take;
  logic eng_go, eng_busy, eng_fin;
  bus_kind_t eng_kind;
  logic [7:0] eng_byte, eng_rbyte;
  logic plane_clash, order_bad;
  logic wait_start, wait_ready, wait_tmo;
  logic [15:0] cur_col16;
  logic [23:0] cur_row24;

  assign cur_col16 = 16'(pl ? col_b_q : col_a_q);
  assign cur_row24 = 24'(pl ? row_b_q : row_a_q);

  assign req_ready  = (st == S_IDLE);
  assign evt_accept = (st == S_IDLE) && req_valid && !plane_clash && !order_bad;
  assign evt_reject = (st == S_IDLE) && req_valid && (plane_clash || order_bad);
  assign wait_start = (st == S_CONF) && eng_fin;
  assign done       = (st == S_DONE);
  assign err_code   = err_q;
  assign nand_ce_n  = (st == S_IDLE) || (st == S_DONE);

  function automatic logic [7:0] close_op(input logic plane_b, input logic fin_pg);
    if (!plane_b) return OP_DUMMY;
    return fin_pg ? OP_FINAL : OP_CACHE;
  endfunction

  nand_page_order #(.PAGE_W(PAGE_W), .BLK_W(BLK_W)) u_order (
    .clk(clk), .rst_n(rst_n), .row_a(req_row_a), .row_b(req_row_b),
    .commit(evt_accept), .plane_clash(plane_clash), .order_bad(order_bad)
  );

  nand_busy_wait #(.T_WB(T_WB), .T_BUSY_MAX(T_BUSY_MAX)) u_wait (
    .clk(clk), .rst_n(rst_n), .start(wait_start), .rb_n(nand_rb_n),
    .ready_evt(wait_ready), .timeout_evt(wait_tmo)
  );

  nand_bus_cycle #(.T_SU(T_SU), .T_WP(T_WP), .T_HLD(T_HLD)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .kind(eng_kind), .wbyte(eng_byte),
    .io_in(nand_io_in), .busy(eng_busy), .fin(eng_fin), .rbyte(eng_rbyte),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .io_out(nand_io_out), .io_oe(nand_io_oe)
  );

  always_comb begin
    eng_go   = 1'b0;
    eng_kind = BK_CMD;
    eng_byte = 8'h00;
    in_ready = 1'b0;
    if (!eng_busy) begin
      case (st)
        S_PCMD:   begin eng_go = 1'b1; eng_byte = OP_LOAD; end
        S_ADDR:   begin
          eng_go = 1'b1; eng_kind = BK_ADDR;
          eng_byte = addr_byte(cur_col16, cur_row24, aidx);
        end
        S_DATA:   if (in_valid) begin
          in_ready = 1'b1;
          if (!in_jump) begin
            eng_go = 1'b1; eng_kind = BK_DATA; eng_byte = in_data;
          end
        end
        S_JCMD:   begin eng_go = 1'b1; eng_byte = OP_JUMP; end
        S_JADDR:  begin
          eng_go = 1'b1; eng_kind = BK_ADDR;
          eng_byte = jidx ? 16'(jcol_q) >> 8 : 8'(jcol_q);
        end
        S_CONF:   begin eng_go = 1'b1; eng_byte = close_op(pl, final_q); end
        S_STCMD:  begin eng_go = 1'b1; eng_byte = OP_STATUS; end
        S_STRD:   begin eng_go = 1'b1; eng_kind = BK_READ; end
        S_RSTCMD: begin eng_go = 1'b1; eng_byte = OP_RESET; end
        default:  ;
      endcase
    end
  end

  assign evt_take = (st == S_DATA) && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pl      <= 1'b0;
      aidx    <= '0;
      jidx    <= 1'b0;
      last_q  <= 1'b0;
      final_q <= 1'b0;
      row_a_q <= '0;
      row_b_q <= '0;
      col_a_q <= '0;
      col_b_q <= '0;
      jcol_q  <= '0;
      err_q   <= EC_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          row_a_q <= req_row_a;
          row_b_q <= req_row_b;
          col_a_q <= req_col_a;
          col_b_q <= req_col_b;
          final_q <= req_final;
          pl      <= 1'b0;
          if (plane_clash)    begin err_q <= EC_PLANE; st <= S_DONE; end
          else if (order_bad) begin err_q <= EC_ORDER; st <= S_DONE; end
          else                begin err_q <= EC_OK;    st <= S_PCMD; end
        end
        S_PCMD: if (eng_fin) begin aidx <= '0; st <= S_ADDR; end
        S_ADDR: if (eng_fin) begin
          if (aidx == 3'd4) st <= S_DATA;
          else              aidx <= aidx + 1'b1;
        end
        S_DATA: begin
          if (evt_take) begin
            last_q <= in_last;
            if (in_jump) begin
              jcol_q <= in_col;
              jidx   <= 1'b0;
              st     <= S_JCMD;
            end
          end
          if (eng_fin && last_q) st <= S_CONF;
        end
        S_JCMD: if (eng_fin) st <= S_JADDR;
        S_JADDR: if (eng_fin) begin
          if (jidx) st <= last_q ? S_CONF : S_DATA;
          else      jidx <= 1'b1;
        end
        S_CONF: if (eng_fin) st <= S_WAIT;
        S_WAIT: begin
          if (wait_ready) begin
            if (pl) st <= S_STCMD;
            else begin pl <= 1'b1; st <= S_PCMD; end
          end else if (wait_tmo) begin
            err_q <= EC_TIMEOUT;
            st    <= S_RSTCMD;
          end
        end
        S_STCMD: if (eng_fin) st <= S_STRD;
        S_STRD: if (eng_fin) begin
          err_q <= eng_rbyte[0] ? EC_PROGFAIL : EC_OK;
          st    <= S_DONE;
        end
        S_RSTCMD: if (eng_fin) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_2p_cache_prog_chk.sv
module nand_2p_cache_prog_chk #(
  parameter int T_WP = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_io_out,
  input logic       nand_rb_n,
  input logic       done,
  input logic       evt_accept,
  input logic       evt_reject
);
  localparam int CW = $clog2(T_WP + 2) + 1;
  logic [CW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (!nand_we_n) low_run <= low_run + 1'b1;
    else                 low_run <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (low_run == CW'(T_WP)));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale)));

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R4
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_rb_n && !nand_we_n) |-> (nand_cle && (nand_io_out == 8'h70 || nand_io_out == 8'hFF)));

  // R7
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reject |=> (nand_ce_n && done));

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> !nand_ce_n);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind nand_2p_cache_prog nand_2p_cache_prog_chk #(.T_WP(T_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_io_out(nand_io_out), .nand_rb_n(nand_rb_n), .done(done),
  .evt_accept(evt_accept), .evt_reject(evt_reject)
);

// File: tb/tb_nand_2p_cache_prog.sv
`timescale 1ns/1ps
module tb_nand_2p_cache_prog;
  localparam int COL_W = 13, PAGE_W = 6, BLK_W = 5, ROW_W = PAGE_W + BLK_W;
  localparam int T_WP = 2, TMO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_final = 1'b0;
  logic req_ready, in_ready, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic nand_io_oe, done;
  logic [ROW_W-1:0] req_row_a = '0, req_row_b = '0;
  logic [COL_W-1:0] req_col_a = '0, req_col_b = '0;
  logic [7:0] nand_io_out, nand_io_in;
  logic [2:0] err_code;
  logic nand_rb_n = 1'b1;

  // stream source
  logic [7:0]       bd [16];
  logic             bj [16];
  logic             bl [16];
  logic [COL_W-1:0] bc [16];
  int sb_n = 0, sb_idx = 0;
  logic sb_clr = 1'b0;
  logic in_valid, in_jump, in_last;
  logic [7:0] in_data;
  logic [COL_W-1:0] in_col;
  assign in_valid = sb_idx < sb_n;
  assign in_data  = bd[sb_idx[3:0]];
  assign in_jump  = bj[sb_idx[3:0]];
  assign in_last  = bl[sb_idx[3:0]];
  assign in_col   = bc[sb_idx[3:0]];
  always @(posedge clk) begin
    if (sb_clr) sb_idx <= 0;
    else if (in_valid && in_ready) sb_idx <= sb_idx + 1;
  end

  logic tb_fail = 1'b0, hang = 1'b0;
  int bsy_len = 10;
  assign nand_io_in = {1'b0, 1'b1, 5'b0, tb_fail};

  nand_2p_cache_prog #(.COL_W(COL_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W), .T_WP(T_WP),
                       .T_BUSY_MAX(TMO)) dut (.*);

  // bus write log and flash model
  logic [9:0] logv [2048];
  int nlog = 0, ff_cnt = 0, busy_wr = 0, wp_bad = 0, lowcnt = 0;
  event conf_ev;
  always @(posedge nand_we_n) begin
    if (nlog < 2048) logv[nlog] = {nand_cle, nand_ale, nand_io_out};
    nlog = nlog + 1;
    if (!nand_rb_n && !(nand_cle && (nand_io_out == 8'h70 || nand_io_out == 8'hFF)))
      busy_wr = busy_wr + 1;
    if (nand_cle && nand_io_out == 8'hFF) ff_cnt = ff_cnt + 1;
    if (nand_cle && (nand_io_out == 8'h11 || nand_io_out == 8'h15 || nand_io_out == 8'h10))
      -> conf_ev;
  end
  always @(posedge clk) begin
    if (!nand_we_n) lowcnt = lowcnt + 1;
    else begin
      if (lowcnt != 0 && lowcnt != T_WP) wp_bad = wp_bad + 1;
      lowcnt = 0;
    end
  end
  always begin
    @(conf_ev);
    @(posedge clk);
    nand_rb_n <= 1'b0;
    if (hang) begin
      int f0;
      f0 = ff_cnt;
      while (ff_cnt == f0) @(posedge clk);
    end else repeat (bsy_len) @(posedge clk);
    nand_rb_n <= 1'b1;
  end

  int vec = 0, errs = 0;
  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench reference
  logic [9:0] ex [64];
  int exn;
  logic [PAGE_W-1:0] m_last [32];
  logic m_seen [32];
  task automatic push(input logic [1:0] k, input logic [7:0] b);
    ex[exn] = {k, b}; exn++;
  endtask
  function automatic logic [7:0] abyte(input logic [COL_W-1:0] c, input logic [ROW_W-1:0] r, input int i);
    logic [39:0] w;
    w = {16'(0), 24'(r)} | {24'(0), 16'(c)} << 0;
    w = {24'(r), 16'(c)};
    return w[8*i +: 8];
  endfunction
  task automatic push_plane(input logic [COL_W-1:0] c, input logic [ROW_W-1:0] r,
                            input int b0, input int b1);
    push(2'b10, 8'h80);
    for (int i = 0; i < 5; i++) push(2'b01, abyte(c, r, i));
    for (int i = b0; i < b1; i++) begin
      if (bj[i]) begin
        push(2'b10, 8'h85); push(2'b01, 8'(16'(bc[i]))); push(2'b01, 8'(16'(bc[i]) >> 8));
      end else push(2'b00, bd[i]);
    end
  endtask

  int na, nb;
  task automatic gen_beats();
    na = 1 + $urandom % 5; nb = 1 + $urandom % 5;
    for (int i = 0; i < na + nb; i++) begin
      bd[i] = 8'($urandom); bj[i] = ($urandom % 4) == 0;
      bc[i] = COL_W'($urandom); bl[i] = (i == na - 1) || (i == na + nb - 1);
    end
  endtask

  task automatic run_req(input logic [BLK_W-1:0] ba, input logic [PAGE_W-1:0] pa,
                         input logic [BLK_W-1:0] bb, input logic [PAGE_W-1:0] pb,
                         input logic fin, input logic hg, input logic fl, input string tag);
    int base, cyc, expc;
    logic [ROW_W-1:0] ra, rb;
    logic [COL_W-1:0] ca, cb;
    ra = {ba, pa}; rb = {bb, pb};
    ca = COL_W'($urandom); cb = COL_W'($urandom);
    if (ba[0] == bb[0]) expc = 1;
    else if ((m_seen[ba] && pa <= m_last[ba]) || (m_seen[bb] && pb <= m_last[bb])) expc = 2;
    else if (hg) expc = 3;
    else expc = fl ? 4 : 0;
    exn = 0;
    if (expc != 1 && expc != 2) begin
      m_seen[ba] = 1'b1; m_last[ba] = pa; m_seen[bb] = 1'b1; m_last[bb] = pb;
      push_plane(ca, ra, 0, na); push(2'b10, 8'h11);
      if (hg) push(2'b10, 8'hFF);
      else begin
        push_plane(cb, rb, na, na + nb); push(2'b10, fin ? 8'h10 : 8'h15);
        push(2'b10, 8'h70);
      end
    end
    @(negedge clk);
    sb_clr = 1'b1; hang = hg; tb_fail = fl; bsy_len = 5 + $urandom % 60;
    @(negedge clk);
    sb_clr = 1'b0; sb_n = na + nb;
    base = nlog;
    req_row_a = ra; req_row_b = rb; req_col_a = ca; req_col_b = cb;
    req_final = fin; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (cyc >= 5000) begin
      errs++; vec++;
      $display("FAIL watchdog %s: actual no done expected done", tag);
    end
    chk({tag, " R6/R7/R8/R9 err_code"}, err_code, expc);
    chk({tag, " R2/R3/R5 write count"}, nlog - base, exn);
    for (int i = 0; i < exn; i++)
      if (logv[base + i] != ex[i]) begin
        chk({tag, " R2/R3 write content"}, logv[base + i], ex[i]);
        break;
      end
    chk("R4 write during busy", busy_wr, 0);
    chk("R10 strobe width", wp_bad, 0);
    @(negedge clk);
    chk({tag, " R1 idle after done"}, {nand_ce_n, req_ready, done}, 3'b110);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) begin m_seen[i] = 1'b0; m_last[i] = '0; end
    for (int i = 0; i < 16; i++) begin bd[i] = 0; bj[i] = 0; bl[i] = 0; bc[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, done},
        7'b1110000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle ready", {req_ready, nand_ce_n}, 2'b11);
    // directed
    gen_beats(); run_req(5'd2, 6'd3, 5'd3, 6'd3, 1'b1, 1'b0, 1'b0, "final");
    gen_beats(); run_req(5'd4, 6'd1, 5'd5, 6'd1, 1'b0, 1'b0, 1'b0, "cache");
    gen_beats(); bj[0] = 1'b1; bj[na - 1] = 1'b1;
    run_req(5'd6, 6'd0, 5'd7, 6'd0, 1'b0, 1'b0, 1'b0, "jump R3");
    gen_beats(); run_req(5'd8, 6'd2, 5'd10, 6'd2, 1'b1, 1'b0, 1'b0, "plane R7");
    gen_beats(); run_req(5'd2, 6'd3, 5'd3, 6'd9, 1'b1, 1'b0, 1'b0, "order R8");
    gen_beats(); run_req(5'd12, 6'd1, 5'd13, 6'd1, 1'b1, 1'b1, 1'b0, "timeout R9");
    gen_beats(); run_req(5'd14, 6'd1, 5'd15, 6'd1, 1'b1, 1'b0, 1'b1, "progfail R6");
    gen_beats(); run_req(5'd2, 6'd4, 5'd3, 6'd4, 1'b0, 1'b0, 1'b0, "ascend R8");
    // random
    for (int n = 0; n < 36; n++) begin
      logic [BLK_W-1:0] ba, bb;
      logic [PAGE_W-1:0] pa, pb;
      ba = BLK_W'($urandom);
      bb = (($urandom % 8) == 0) ? (ba ^ 5'd2) : (ba ^ 5'd1);
      pa = m_seen[ba] ? m_last[ba] + PAGE_W'($urandom % 3) : PAGE_W'($urandom % 8);
      pb = m_seen[bb] ? m_last[bb] + PAGE_W'(1 + $urandom % 2) : PAGE_W'($urandom % 8);
      gen_beats();
      run_req(ba, pa, bb, pb, 1'($urandom), 1'b0, (($urandom % 6) == 0), "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule